// File: doc/BRIEF.md
# Floating-Point Register List Block Mover

This block copies a chosen subset of an eight-entry floating-point register file to memory, or fills that subset from memory. Each register is 96 bits wide and moves as three 32-bit words. A single start pulse begins a transfer and supplies:

- the direction;
- whether the register mask comes from an 8-bit static field or from the low byte of an integer register value;
- whether the address walks downward (predecrement) or upward (postincrement);
- the base address.

The block then issues one word request at a time on a simple request/acknowledge memory port. It waits as long as the memory needs for each word. It reads or writes the register file as it goes.

The addressing mode decides both the visiting order and how mask bits map to registers:

- **Predecrement:** registers are visited from index 7 down to 0, and mask bit n picks register n.
- **Postincrement:** registers are visited from index 0 up to 7, and mask bit 7−n picks register n.

In both modes the memory image has the lower-indexed register at the lower address. Within each register, the most significant word sits at the lowest address. When the transfer ends, the block reports the final address so the caller can update its address register. A faulting memory word ends the transfer at once.

The block does no rounding, no format conversion and no status-flag update. Address-mode decoding belongs to the caller.

Top module: `fp_list_mover`

## Requirements
- R1: After reset, mem_req, done, fault and rf_we are all 0.
- R2: When dyn_list is 1, the mask is int_val[7:0] and static_mask is ignored. When dyn_list is 0, the mask is static_mask.
- R3: When predec is 1, registers are visited from index 7 down to 0, and register n takes part when mask bit n is 1.
- R4: When predec is 0, registers are visited from index 0 up to 7, and register n takes part when mask bit 7−n is 1.
- R5: When predec is 1, each word goes to the current address minus 4, and the address then drops by 4. When predec is 0, each word goes to the current address, and the address then rises by 4. final_addr shows the address after the last completed word.
- R6: Word 0 of a register is bits 95:64, word 1 is bits 63:32, and word 2 is bits 31:0. Word 0 sits at the lowest of the register's three addresses. Postincrement sends words 0, 1, 2 in that order; predecrement sends words 2, 1, 0.
- R7: With to_mem=1, register contents are written to memory (mem_we=1). With to_mem=0, memory words are read, and each selected register receives a single rf_we pulse carrying all 96 bits after its third word.
- R8: A request keeps mem_req, mem_addr and mem_we steady until mem_ack or mem_fault arrives.
- R9: An empty mask raises done in the cycle after the start cycle, issues no memory request, and leaves final_addr equal to base_addr.
- R10: When mem_fault is 1, the block raises done and fault together and issues no further request. A register that is being loaded when the fault occurs is not written. final_addr excludes the faulting word.
- R11: A start pulse while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| to_mem | input | 1 | 1: register file to memory; 0: memory to register file |
| dyn_list | input | 1 | 1: mask from int_val[7:0]; 0: mask from static_mask |
| predec | input | 1 | 1: predecrement walk; 0: postincrement walk |
| static_mask | input | 8 | Static register mask |
| int_val | input | 32 | Integer register value supplying the dynamic mask |
| base_addr | input | 32 | Starting byte address |
| mem_req | output | 1 | Word request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| mem_fault | input | 1 | Request faulted; ends the transfer |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 96 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 96 | Register file write data |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| fault | output | 1 | With done: the transfer ended on a fault |
| final_addr | output | 32 | Address after the last completed word |

## Verification
Different internal faults show up at the ports in different ways:

- **Pending-mask or index error:** the memory access log shows a word at an address or in an order different from the one derived from the mask. This is visible at the very first request of the affected register.
- **Word-counter or slot error:** a 32-bit word lands swapped within a register's three addresses. This is visible in memory or in the register file as soon as that register completes.
- **Address-step error:** final_addr and every later request address are off. This is visible at the first acknowledge.
- **Fault-handling error:** the block keeps requesting after a fault, or a partially loaded register is written. This is visible within one cycle of the fault.

// File: rtl/fp_list_mover.sv
module fp_list_mover #(
  parameter int NREG = 8,
  parameter int WORD = 32,
  parameter int WPR  = 3,
  parameter int AW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 to_mem,
  input  logic                 dyn_list,
  input  logic                 predec,
  input  logic [NREG-1:0]      static_mask,
  input  logic [WORD-1:0]      int_val,
  input  logic [AW-1:0]        base_addr,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [WORD-1:0]      mem_wdata,
  input  logic [WORD-1:0]      mem_rdata,
  input  logic                 mem_ack,
  input  logic                 mem_fault,
  output logic [$clog2(NREG)-1:0] rf_raddr,
  input  logic [WORD*WPR-1:0]  rf_rdata,
  output logic                 rf_we,
  output logic [$clog2(NREG)-1:0] rf_waddr,
  output logic [WORD*WPR-1:0]  rf_wdata,
  output logic                 done,
  output logic                 fault,
  output logic [AW-1:0]        final_addr
);
  localparam int IW   = $clog2(NREG);
  localparam int CW   = $clog2(WPR);
  localparam int RW   = WORD * WPR;
  localparam int STEP = WORD / 8;

  logic            busy_q, predec_q, tomem_q;
  logic [NREG-1:0] pend_q;
  logic [CW-1:0]   wcnt_q;
  logic [AW-1:0]   addr_q;
  logic [RW-1:0]   acc_q;

  logic [NREG-1:0] pick_mask, rev_mask;
  logic [IW-1:0]   first_k, cur_idx;
  logic [CW-1:0]   word_sel;
  int unsigned     word_lo;
  logic [RW-1:0]   acc_next;
  logic            last_word, last_reg;

  assign pick_mask = dyn_list ? int_val[NREG-1:0] : static_mask;

  always_comb begin
    for (int k = 0; k < NREG; k++) rev_mask[k] = pick_mask[NREG-1-k];
  end

  always_comb begin
    first_k = '0;
    for (int k = NREG-1; k >= 0; k--)
      if (pend_q[k]) first_k = IW'(k);
  end

  assign cur_idx  = predec_q ? IW'(NREG-1) - first_k : first_k;
  assign word_sel = predec_q ? CW'(WPR-1) - wcnt_q : wcnt_q;
  assign word_lo  = (WPR - 1 - int'(word_sel)) * WORD;

  always_comb begin
    acc_next = acc_q;
    acc_next[word_lo +: WORD] = mem_rdata;
  end

  assign last_word = (wcnt_q == CW'(WPR-1));
  assign last_reg  = ((pend_q & (pend_q - 1'b1)) == '0);

  assign mem_req    = busy_q;
  assign mem_we     = tomem_q;
  assign mem_addr   = predec_q ? addr_q - AW'(STEP) : addr_q;
  assign mem_wdata  = rf_rdata[word_lo +: WORD];
  assign rf_raddr   = cur_idx;
  assign final_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      predec_q <= 1'b0;
      tomem_q  <= 1'b0;
      pend_q   <= '0;
      wcnt_q   <= '0;
      addr_q   <= '0;
      acc_q    <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      rf_we <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          predec_q <= predec;
          tomem_q  <= to_mem;
          addr_q   <= base_addr;
          wcnt_q   <= '0;
          pend_q   <= rev_mask;
          if (rev_mask == '0) done <= 1'b1;
          else                busy_q <= 1'b1;
        end
      end else if (mem_fault) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
        fault  <= 1'b1;
      end else if (mem_ack) begin
        addr_q <= predec_q ? addr_q - AW'(STEP) : addr_q + AW'(STEP);
        acc_q  <= acc_next;
        if (last_word) begin
          wcnt_q          <= '0;
          pend_q[first_k] <= 1'b0;
          if (!tomem_q) begin
            rf_we    <= 1'b1;
            rf_waddr <= cur_idx;
            rf_wdata <= acc_next;
          end
          if (last_reg) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end

  // R8: an outstanding request holds until answered
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_fault) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10: a fault ends the transfer with done and fault
  assert_fault_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_fault) |=> (!mem_req && done && fault));

  // R5: address moves by one word per acknowledged word
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_fault) |=>
      (final_addr == ($past(predec_q) ? $past(mem_addr) : $past(mem_addr) + AW'(STEP))));

  // R7: register writes only follow an acknowledged read
  assert_rf_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(mem_req && mem_ack && !mem_fault && !mem_we));

  // R11: start during a transfer does not cut it short
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && start && !mem_ack && !mem_fault) |=> mem_req);

  always_ff @(posedge clk) begin
    if (rst_n) assert_fault_done_R10: assert (!fault || done);
  end
endmodule

// File: tb/fp_list_mover_tb.sv
`timescale 1ns/1ps
module fp_list_mover_tb;
  logic clk = 0, rst_n = 0;
  logic start = 0, to_mem = 0, dyn_list = 0, predec = 0;
  logic [7:0] static_mask = 0;
  logic [31:0] int_val = 0, base_addr = 0;
  logic mem_req, mem_we, mem_ack = 0, mem_fault = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0, final_addr;
  logic [2:0] rf_raddr, rf_waddr;
  logic [95:0] rf_rdata, rf_wdata;
  logic rf_we, done, fault;

  always #2.5 clk = ~clk;

  fp_list_mover u_dut (.clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
    .dyn_list(dyn_list), .predec(predec), .static_mask(static_mask), .int_val(int_val),
    .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_fault(mem_fault),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .done(done), .fault(fault), .final_addr(final_addr));

  logic [31:0] mem_m [64];
  logic [31:0] mem_init [64];
  logic [95:0] rf_m [8];
  logic [95:0] rf_init [8];
  logic [31:0] log_addr [64];
  logic        log_we [64];
  int acc_cnt = 0, wait_cnt = 0, lat_cfg = 0, fault_at = -1;
  bit init_req = 0;
  int checks = 0, failures = 0;

  assign rf_rdata = rf_m[rf_raddr];

  always @(negedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 64; i++) begin mem_m[i] = 32'h5000_0000 + 32'(i) * 32'h111; mem_init[i] = mem_m[i]; end
      for (int n = 0; n < 8; n++) begin
        rf_m[n] = {32'hA000_0000 | (32'(n) << 8), 32'hB000_0001 | (32'(n) << 8), 32'hC000_0002 | (32'(n) << 8)};
        rf_init[n] = rf_m[n];
      end
      acc_cnt = 0; wait_cnt = 0; init_req = 0;
    end
    if (rf_we) rf_m[rf_waddr] = rf_wdata;
    mem_ack = 0; mem_fault = 0;
    if (mem_req) begin
      if (wait_cnt < lat_cfg) wait_cnt++;
      else begin
        wait_cnt = 0;
        mem_ack = 1;
        if (acc_cnt < 64) begin log_addr[acc_cnt] = mem_addr; log_we[acc_cnt] = mem_we; end
        if (acc_cnt == fault_at) mem_fault = 1;
        else if (mem_we) mem_m[mem_addr[7:2]] = mem_wdata;
        else mem_rdata = mem_m[mem_addr[7:2]];
        acc_cnt++;
      end
    end else wait_cnt = 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wsel(input logic [95:0] r, input int w);
    return r[95 - 32*w -: 32];
  endfunction

  function automatic bit selected(input bit pd, input logic [7:0] m, input int n);
    return pd ? m[n] : m[7-n];
  endfunction

  task automatic prep(input int lat, input int fat);
    @(negedge clk); init_req = 1; lat_cfg = lat; fault_at = fat;
    @(negedge clk); #1;
  endtask

  task automatic launch(input bit tm, input bit dl, input bit pd, input logic [7:0] sm,
                        input logic [31:0] iv, input logic [31:0] ba);
    to_mem = tm; dyn_list = dl; predec = pd; static_mask = sm; int_val = iv; base_addr = ba;
    start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output bit f, output logic [31:0] fa);
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R8", "transfer finished", 96'(t), 96'(0));
    f = fault; fa = final_addr;
    @(negedge clk);
  endtask

  task automatic check_store(input bit pd, input logic [7:0] m, input logic [31:0] ba,
                             input logic [31:0] fa, input string req);
    logic [31:0] a = ba; int cnt = 0;
    if (!pd) begin
      for (int n = 0; n < 8; n++) if (selected(pd, m, n))
        for (int w = 0; w < 3; w++) begin
          chk(mem_m[a[7:2]] == wsel(rf_m[n], w), req, "stored word", 96'(mem_m[a[7:2]]), 96'(wsel(rf_m[n], w)));
          if (cnt == 0) chk(log_addr[0] == a, "R6", "first word address", 96'(log_addr[0]), 96'(a));
          a += 4; cnt++;
        end
    end else begin
      for (int n = 7; n >= 0; n--) if (selected(pd, m, n))
        for (int w = 2; w >= 0; w--) begin
          a -= 4;
          chk(mem_m[a[7:2]] == wsel(rf_m[n], w), req, "stored word", 96'(mem_m[a[7:2]]), 96'(wsel(rf_m[n], w)));
          chk(log_addr[cnt] == a, "R6", "access order", 96'(log_addr[cnt]), 96'(a));
          cnt++;
        end
    end
    chk(fa == a, "R5", "final address", 96'(fa), 96'(a));
    chk(acc_cnt == cnt, req, "access count", 96'(acc_cnt), 96'(cnt));
    chk(log_we[0] == 1'b1, "R7", "write direction", 96'(log_we[0]), 96'(1));
  endtask

  task automatic check_load(input bit pd, input logic [7:0] m, input logic [31:0] ba,
                            input logic [31:0] fa, input string req);
    logic [31:0] a = ba; int cnt = 0; logic [95:0] e;
    if (!pd) begin
      for (int n = 0; n < 8; n++) if (selected(pd, m, n)) begin
        e = {mem_init[a[7:2]], mem_init[a[7:2]+1], mem_init[a[7:2]+2]};
        chk(rf_m[n] == e, req, "loaded register", rf_m[n], e);
        a += 12; cnt += 3;
      end
    end else begin
      for (int n = 7; n >= 0; n--) if (selected(pd, m, n)) begin
        a -= 12;
        e = {mem_init[a[7:2]], mem_init[a[7:2]+1], mem_init[a[7:2]+2]};
        chk(rf_m[n] == e, req, "loaded register", rf_m[n], e);
        cnt += 3;
      end
    end
    for (int n = 0; n < 8; n++) if (!selected(pd, m, n))
      chk(rf_m[n] == rf_init[n], req, "unselected register untouched", rf_m[n], rf_init[n]);
    chk(fa == a, "R5", "final address", 96'(fa), 96'(a));
    chk(acc_cnt == cnt, req, "access count", 96'(acc_cnt), 96'(cnt));
    chk(log_we[0] == 1'b0, "R7", "read direction", 96'(log_we[0]), 96'(0));
  endtask

  task automatic t_reset;
    chk(!mem_req && !done && !fault && !rf_we, "R1", "idle after reset",
        96'({mem_req, done, fault, rf_we}), 96'(0));
  endtask

  task automatic t_store_post;
    bit f; logic [31:0] fa;
    prep(0, -1);
    launch(1, 0, 0, 8'b1010_0001, 32'h0, 32'h10);
    wait_done(f, fa);
    chk(!f, "R4", "no fault", 96'(f), 96'(0));
    check_store(0, 8'b1010_0001, 32'h10, fa, "R4");
  endtask

  task automatic t_store_pre;
    bit f; logic [31:0] fa;
    prep(1, -1);
    launch(1, 0, 1, 8'b1000_0110, 32'h0, 32'hC0);
    wait_done(f, fa);
    check_store(1, 8'b1000_0110, 32'hC0, fa, "R3");
  endtask

  task automatic t_load_post_dyn;
    bit f; logic [31:0] fa;
    prep(2, -1);
    launch(0, 1, 0, 8'hFF, 32'hFFFF_FF4C, 32'h20);
    wait_done(f, fa);
    check_load(0, 8'h4C, 32'h20, fa, "R2");
  endtask

  task automatic t_load_pre;
    bit f; logic [31:0] fa;
    prep(0, -1);
    launch(0, 0, 1, 8'h81, 32'hFFFF_FFFF, 32'hF0);
    wait_done(f, fa);
    check_load(1, 8'h81, 32'hF0, fa, "R3");
  endtask

  task automatic t_empty;
    prep(0, -1);
    launch(1, 0, 0, 8'h00, 32'hFF, 32'h44);
    chk(done == 1'b1, "R9", "done one cycle after start", 96'(done), 96'(1));
    chk(final_addr == 32'h44, "R9", "final address equals base", 96'(final_addr), 96'h44);
    @(negedge clk);
    chk(done == 1'b0 && acc_cnt == 0, "R9", "no traffic", 96'(acc_cnt), 96'(0));
  endtask

  task automatic t_fault_store;
    bit f; logic [31:0] fa;
    prep(0, 4);
    launch(1, 0, 0, 8'hFF, 32'h0, 32'h10);
    wait_done(f, fa);
    repeat (3) @(negedge clk);
    chk(f == 1'b1, "R10", "fault reported", 96'(f), 96'(1));
    chk(acc_cnt == 5, "R10", "no access after fault", 96'(acc_cnt), 96'(5));
    chk(fa == 32'h20, "R10", "final address excludes faulting word", 96'(fa), 96'h20);
    chk(mem_m[32'h20 >> 2] == mem_init[32'h20 >> 2], "R10", "faulting word not written",
        96'(mem_m[8]), 96'(mem_init[8]));
  endtask

  task automatic t_fault_load;
    bit f; logic [31:0] fa; logic [95:0] e;
    prep(1, 4);
    launch(0, 0, 1, 8'h03, 32'h0, 32'h80);
    wait_done(f, fa);
    e = {mem_init[29], mem_init[30], mem_init[31]};
    chk(f == 1'b1, "R10", "fault reported", 96'(f), 96'(1));
    chk(rf_m[1] == e, "R10", "completed register kept", rf_m[1], e);
    chk(rf_m[0] == rf_init[0], "R10", "partial register not written", rf_m[0], rf_init[0]);
    chk(fa == 32'h70, "R10", "final address", 96'(fa), 96'h70);
  endtask

  task automatic t_start_busy;
    bit f; logic [31:0] fa;
    prep(3, -1);
    launch(1, 0, 0, 8'h80, 32'h0, 32'h30);
    @(negedge clk);
    predec = 1; static_mask = 8'hFF; base_addr = 32'hE0; start = 1;
    @(negedge clk); start = 0;
    wait_done(f, fa);
    repeat (20) @(negedge clk);
    chk(acc_cnt == 3, "R11", "second start ignored", 96'(acc_cnt), 96'(3));
    chk(fa == 32'h3C, "R11", "first transfer final address", 96'(fa), 96'h3C);
    chk(mem_m[12] == wsel(rf_m[0], 0), "R6", "word 0 at lowest address", 96'(mem_m[12]), 96'(wsel(rf_m[0], 0)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_store_post();
    t_store_pre();
    t_load_post_dyn();
    t_load_pre();
    t_empty();
    t_fault_store();
    t_fault_load();
    t_start_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule